// File: doc/BRIEF.md
# Bus-activity watchdog timer

This block supervises a processor by watching the two-wire serial bus that the processor drives. Every complete bus transaction the processor makes, to any slave address, proves the processor is alive and restarts a cycle counter. If the counter reaches the selected timeout before another transaction completes, the block raises a watchdog reset pulse of fixed width. It then reloads and starts counting again.

A transaction counts as activity only if it contains the minimal shape of a real transfer. That shape is a start condition, then the clock going low, then the clock going high, and finally a stop condition. The restart takes effect on the stop. A two-bit period field picks one of three timeouts or turns the watchdog off. The processor writes this field through a one-cycle write strobe. A write-protect level locks the field against changes.

The SCL and SDA inputs must already be synchronised to `clk`. The supervisor reset is synchronous and active high. It clears the timer, the sequence detector and the period field.

Top module: `bus_watchdog`

## Requirements
- R1: A start is SDA going from 1 to 0 while SCL is 1 in two consecutive clock samples. A stop is SDA going from 0 to 1 while SCL is 1 in two consecutive samples. A start, then SCL low, then SCL high, then a stop, reloads the counter on the clock edge that samples the stop. The reset output then rises on the edge that comes the selected timeout count of cycles after that edge.
- R2: A longer transaction also restarts the timer when it ends in a stop. Such a transaction may have several clock pulses, changes of SDA while SCL is low, and a repeated start.
- R3: Two cases do not restart the timer. One is a start followed by another start with no stop between them. The other is a start followed directly by a stop with no SCL low/high pulse between them.
- R4: Period field value 2'b00 selects `T_LONG` cycles, 2'b01 selects `T_MED` cycles and 2'b10 selects `T_SHORT` cycles.
- R5: Period field value 2'b11 disables the watchdog: the counter is held at its reload value and no reset pulse starts. After a switch back to a timeout code, counting starts from reload.
- R6: A write strobe with write-protect low loads the two data bits into the period field. While write-protect is high, writes are ignored and the field keeps its value.
- R7: On expiry the reset output stays high for exactly `PULSE_W` cycles. The counter then reloads and resumes, so expiries repeat every timeout plus `PULSE_W` cycles.
- R8: While the supervisor reset is high, the reset output is low and the counter stays at its reload value. The reset also clears the sequence detector and sets the period field to 2'b00. A reset in the middle of a pulse ends that pulse on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Supervisor reset, synchronous, active high |
| scl_i | input | 1 | Synchronised serial clock line |
| sda_i | input | 1 | Synchronised serial data line |
| wp_i | input | 1 | Write-protect level; high locks the period field |
| cfg_we_i | input | 1 | One-cycle write strobe for the period field |
| cfg_wdata_i | input | 2 | Period code to write |
| wdt_rst_o | output | 1 | Watchdog reset pulse, active high |

## Verification
The assertions assume that SCL and SDA are clean, synchronised levels that change at most once per clock. They also assume that the supervisor reset is high on the first clock edge, so the detector's two-sample history is valid whenever a stop is judged. The bench drives both lines only at falling clock edges, one level change per step. It holds reset for several cycles before each scenario. It changes write-protect only away from a write strobe, so each lock or unlock is seen cleanly before the write it governs.

// File: rtl/bwd_pkg.sv
package bwd_pkg;

    typedef enum logic [1:0] {
        PER_LONG  = 2'b00,
        PER_MED   = 2'b01,
        PER_SHORT = 2'b10,
        PER_OFF   = 2'b11
    } per_sel_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_START,
        SQ_LOW,
        SQ_HIGH
    } seq_st_e;

    typedef enum logic {
        TM_RUN,
        TM_PULSE
    } tm_st_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_lo;
        logic scl_hi;
    } bus_ev_t;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/bwd_seq_det.sv
module bwd_seq_det (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic kick_o
);
    import bwd_pkg::*;

    logic    scl_q;
    logic    sda_q;
    bus_ev_t ev;
    seq_st_e st_q;
    seq_st_e st_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    always_comb begin
        ev.start  = scl_q & scl_i & sda_q & ~sda_i;
        ev.stop   = scl_q & scl_i & ~sda_q & sda_i;
        ev.scl_lo = ~scl_i;
        ev.scl_hi = scl_i;
    end

    always_comb begin
        st_d = st_q;
        if (ev.start) begin
            st_d = SQ_START;
        end else begin
            case (st_q)
                SQ_IDLE:  st_d = SQ_IDLE;
                SQ_START: begin
                    if (ev.stop)        st_d = SQ_IDLE;
                    else if (ev.scl_lo) st_d = SQ_LOW;
                end
                SQ_LOW: begin
                    if (ev.scl_hi)      st_d = SQ_HIGH;
                end
                SQ_HIGH: begin
                    if (ev.stop)        st_d = SQ_IDLE;
                    else if (ev.scl_lo) st_d = SQ_LOW;
                end
                default:                st_d = SQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= SQ_IDLE;
        else     st_q <= st_d;
    end

    assign kick_o = (st_q == SQ_HIGH) && ev.stop;

endmodule

// File: rtl/bwd_per_reg.sv
module bwd_per_reg #(
    parameter bwd_pkg::per_sel_e RST_SEL = bwd_pkg::PER_LONG
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wp_i,
    input  logic              we_i,
    input  logic [1:0]        wdata_i,
    output bwd_pkg::per_sel_e sel_o
);
    import bwd_pkg::*;

    per_sel_e sel_q;

    always_ff @(posedge clk) begin
        if (rst)               sel_q <= RST_SEL;
        else if (we_i && !wp_i) sel_q <= per_sel_e'(wdata_i);
    end

    assign sel_o = sel_q;

endmodule

// File: rtl/bwd_timer.sv
module bwd_timer #(
    parameter int T_LONG  = 1600000,
    parameter int T_MED   = 400000,
    parameter int T_SHORT = 100000,
    parameter int PULSE_W = 40000
) (
    input  logic              clk,
    input  logic              rst,
    input  bwd_pkg::per_sel_e sel_i,
    input  logic              kick_i,
    output logic              wdt_o
);
    import bwd_pkg::*;

    localparam int CNT_W = $clog2(max3(T_LONG, T_MED, T_SHORT) + 1);
    localparam int PW_W  = $clog2(PULSE_W + 1);
    localparam logic [CNT_W-1:0] END_LONG  = CNT_W'(T_LONG - 1);
    localparam logic [CNT_W-1:0] END_MED   = CNT_W'(T_MED - 1);
    localparam logic [CNT_W-1:0] END_SHORT = CNT_W'(T_SHORT - 1);
    localparam logic [PW_W-1:0]  END_PW    = PW_W'(PULSE_W - 1);

    tm_st_e           st_q;
    logic [CNT_W-1:0] cnt_q;
    logic [PW_W-1:0]  pcnt_q;
    logic [CNT_W-1:0] cnt_end;

    always_comb begin
        case (sel_i)
            PER_MED:   cnt_end = END_MED;
            PER_SHORT: cnt_end = END_SHORT;
            default:   cnt_end = END_LONG;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= TM_RUN;
            cnt_q  <= '0;
            pcnt_q <= '0;
        end else begin
            case (st_q)
                TM_RUN: begin
                    if (sel_i == PER_OFF || kick_i) begin
                        cnt_q <= '0;
                    end else if (cnt_q >= cnt_end) begin
                        st_q   <= TM_PULSE;
                        cnt_q  <= '0;
                        pcnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                TM_PULSE: begin
                    if (pcnt_q == END_PW) begin
                        st_q  <= TM_RUN;
                        cnt_q <= '0;
                    end else begin
                        pcnt_q <= pcnt_q + 1'b1;
                    end
                end
                default: st_q <= TM_RUN;
            endcase
        end
    end

    assign wdt_o = (st_q == TM_PULSE);

endmodule

// File: rtl/bus_watchdog.sv
module bus_watchdog #(
    parameter int                T_LONG  = 1600000,
    parameter int                T_MED   = 400000,
    parameter int                T_SHORT = 100000,
    parameter int                PULSE_W = 40000,
    parameter bwd_pkg::per_sel_e RST_SEL = bwd_pkg::PER_LONG
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic       wp_i,
    input  logic       cfg_we_i,
    input  logic [1:0] cfg_wdata_i,
    output logic       wdt_rst_o
);
    import bwd_pkg::*;

    logic     kick;
    per_sel_e sel_q;

    bwd_seq_det seq_i (
        .clk    (clk),
        .rst    (rst),
        .scl_i  (scl_i),
        .sda_i  (sda_i),
        .kick_o (kick)
    );

    bwd_per_reg #(.RST_SEL(RST_SEL)) per_i (
        .clk     (clk),
        .rst     (rst),
        .wp_i    (wp_i),
        .we_i    (cfg_we_i),
        .wdata_i (cfg_wdata_i),
        .sel_o   (sel_q)
    );

    bwd_timer #(
        .T_LONG  (T_LONG),
        .T_MED   (T_MED),
        .T_SHORT (T_SHORT),
        .PULSE_W (PULSE_W)
    ) tmr_i (
        .clk    (clk),
        .rst    (rst),
        .sel_i  (sel_q),
        .kick_i (kick),
        .wdt_o  (wdt_rst_o)
    );

endmodule

// File: rtl/bwd_chk.sv
module bwd_chk #(
    parameter int PULSE_W = 40000
) (
    input logic       clk,
    input logic       rst,
    input logic       scl_i,
    input logic       sda_i,
    input logic       wp_i,
    input logic [1:0] sel_q,
    input logic       kick,
    input logic       wdt
);
    localparam int HC_W = $clog2(PULSE_W + 2);

    logic [HC_W-1:0] hcnt;

    always_ff @(posedge clk) begin
        if (rst || !wdt)            hcnt <= '0;
        else if (hcnt < HC_W'(PULSE_W)) hcnt <= hcnt + 1'b1;
    end

    // R7
    pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
        !(wdt && hcnt >= HC_W'(PULSE_W)));

    // R8
    rst_quiet_chk: assert property (@(posedge clk)
        rst |=> !wdt);

    // R5
    off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (sel_q == 2'b11 && !wdt) |=> !wdt);

    // R6
    wp_lock_chk: assert property (@(posedge clk) disable iff (rst)
        wp_i |=> $stable(sel_q));

    // R1
    kick_on_stop_chk: assert property (@(posedge clk) disable iff (rst)
        kick |-> (scl_i && sda_i && $past(scl_i) && !$past(sda_i)));

endmodule

bind bus_watchdog bwd_chk #(.PULSE_W(PULSE_W)) chk_i (
    .clk   (clk),
    .rst   (rst),
    .scl_i (scl_i),
    .sda_i (sda_i),
    .wp_i  (wp_i),
    .sel_q (sel_q),
    .kick  (kick),
    .wdt   (wdt_rst_o)
);

// File: tb/bus_watchdog_tb_top.sv
`timescale 1ns/1ps
module bus_watchdog_tb_top;

    localparam int LONG  = 64;
    localparam int MED   = 40;
    localparam int SHORT = 24;
    localparam int PW    = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl = 1'b1;
    logic       sda = 1'b1;
    logic       wp  = 1'b0;
    logic       we  = 1'b0;
    logic [1:0] wdata = 2'b00;
    logic       wdt;

    int cyc    = 0;
    int n_chk  = 0;
    int n_fail = 0;
    int rel_c  = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    bus_watchdog #(
        .T_LONG(LONG), .T_MED(MED), .T_SHORT(SHORT), .PULSE_W(PW)
    ) dut_i (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda), .wp_i(wp),
        .cfg_we_i(we), .cfg_wdata_i(wdata), .wdt_rst_o(wdt)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // reset held, released at a falling edge; rel_c marks the release
    task automatic do_reset(input int hold);
        @(negedge clk);
        rst = 1'b1; scl = 1'b1; sda = 1'b1; we = 1'b0; wp = 1'b0;
        repeat (hold) @(negedge clk);
        rst = 1'b0;
        rel_c = cyc;
    endtask

    task automatic drive(input logic s, input logic d);
        @(negedge clk);
        scl = s; sda = d;
    endtask

    task automatic wr(input logic [1:0] v);
        @(negedge clk);
        we = 1'b1; wdata = v;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic wait_rise(output int c);
        int n = 0;
        c = -1;
        while (n < 1000) begin
            @(negedge clk);
            if (wdt) begin c = cyc; break; end
            n++;
        end
    endtask

    task automatic t_reset_state();
        int seen = 0;
        int r;
        do_reset(1);
        @(negedge clk);
        rst = 1'b1;
        for (int i = 0; i < 2 * LONG; i++) begin
            @(negedge clk);
            if (wdt) seen++;
        end
        check(seen == 0, "R8 output low while held in reset", seen, 0);
        rst = 1'b0; rel_c = cyc;
        wait_rise(r);
        check(r - rel_c == LONG, "R4 code 00 timeout after reset", r - rel_c, LONG);
    endtask

    task automatic t_pulse();
        int a, b, n;
        do_reset(3);
        wait_rise(a);
        n = 1;
        forever begin
            @(negedge clk);
            if (!wdt) break;
            n++;
        end
        check(n == PW, "R7 pulse width", n, PW);
        wait_rise(b);
        check(b - a == PW + LONG, "R7 reload and resume period", b - a, PW + LONG);
    endtask

    task automatic t_min_kick();
        int c, r;
        do_reset(3);
        wr(2'b10);
        drive(1, 0); drive(0, 0); drive(1, 0); drive(1, 1);
        c = cyc;
        wait_rise(r);
        check(r - c == SHORT + 1, "R1 minimal sequence restarts on stop", r - c, SHORT + 1);
    endtask

    task automatic t_long_txn();
        int c, r;
        do_reset(3);
        wr(2'b10);
        drive(1, 0);
        drive(0, 1); drive(1, 1);
        drive(0, 0); drive(1, 0);
        drive(0, 1); drive(1, 1);
        drive(1, 0);
        drive(0, 0); drive(1, 0);
        drive(1, 1);
        c = cyc;
        wait_rise(r);
        check(r - c == SHORT + 1, "R2 transaction with repeated start restarts", r - c, SHORT + 1);
    endtask

    task automatic t_no_kick();
        int r;
        do_reset(3);
        wr(2'b10);
        drive(1, 0); drive(0, 0); drive(1, 0);
        drive(0, 0); drive(0, 1); drive(1, 1); drive(1, 0);
        wait_rise(r);
        check(r - rel_c == SHORT, "R3 start then start gives no restart", r - rel_c, SHORT);
        do_reset(3);
        wr(2'b10);
        drive(1, 0); drive(1, 1);
        wait_rise(r);
        check(r - rel_c == SHORT, "R3 stop without clock pulse gives no restart", r - rel_c, SHORT);
    endtask

    task automatic t_periods();
        int r;
        do_reset(3);
        wr(2'b01);
        wait_rise(r);
        check(r - rel_c == MED, "R4 code 01 timeout", r - rel_c, MED);
        do_reset(3);
        wr(2'b10);
        wait_rise(r);
        check(r - rel_c == SHORT, "R4 code 10 timeout", r - rel_c, SHORT);
    endtask

    task automatic t_disable();
        int seen = 0;
        int c, r;
        do_reset(3);
        wr(2'b11);
        for (int i = 0; i < 3 * LONG; i++) begin
            @(negedge clk);
            if (wdt) seen++;
        end
        check(seen == 0, "R5 code 11 gives no pulse", seen, 0);
        wr(2'b10);
        c = cyc;
        wait_rise(r);
        check(r - c == SHORT, "R5 counting restarts from reload after enable", r - c, SHORT);
    endtask

    task automatic t_wp();
        int r;
        do_reset(3);
        @(negedge clk);
        wp = 1'b1;
        wr(2'b10);
        @(negedge clk);
        wp = 1'b0;
        wait_rise(r);
        check(r - rel_c == LONG, "R6 write ignored while protected", r - rel_c, LONG);
        do_reset(3);
        wr(2'b01);
        @(negedge clk);
        wp = 1'b1;
        wr(2'b10);
        wait_rise(r);
        check(r - rel_c == MED, "R6 unprotected write kept, protected one ignored", r - rel_c, MED);
    endtask

    task automatic t_rst_mid();
        int r;
        do_reset(3);
        wr(2'b10);
        wait_rise(r);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(wdt == 1'b0, "R8 reset ends a pulse", int'(wdt), 0);
        rst = 1'b0;
        do_reset(3);
        wr(2'b10);
        drive(1, 0); drive(0, 0); drive(1, 0);
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0; rel_c = cyc;
        drive(1, 1);
        wait_rise(r);
        check(r - rel_c == LONG, "R8 detector and period cleared by reset", r - rel_c, LONG);
    endtask

    initial begin
        #1000000;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset_state();
        t_pulse();
        t_min_kick();
        t_long_txn();
        t_no_kick();
        t_periods();
        t_disable();
        t_wp();
        t_rst_mid();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule